// File: doc/BRIEF.md
# Sample-Hold Conversion Timing Sequencer

This block turns a single trigger pulse into the full timing sequence for a converter that has its own sample-hold stage. In idle the sample-control output is low, so the converter tracks its input. A qualified trigger starts a fixed acquisition window. The block then switches the sample-control output high to hold the value and waits a settle gap. Next it issues a start-convert pulse of fixed width and waits for the converter's end-of-conversion status line to fall. When the status line falls, the block emits a one-cycle data-capture strobe and goes back to sampling.

All durations are parameters counted in system clock cycles. These are the acquisition length, settle gap, start-pulse width, minimum trigger width, minimum trigger spacing and conversion timeout. Before use, the trigger and status inputs each pass through a two-flop synchronizer. A trigger must stay high for a minimum number of synchronized samples to count. A qualified trigger is dropped while a sequence is running, and also when it comes too soon after the previous accepted trigger. If the status line does not complete within the timeout, the block gives up without a capture and raises a sticky error flag.

Top module: `sh_conv_sequencer`

## Requirements
- R1: During and straight after reset, sampleHold, startConv, captureStrobe, busy and timeoutErr are all low.
- R2: A trigger counts only when its synchronized level has been high for MIN_TRIG_CYCLES consecutive samples. A shorter pulse has no effect. A long pulse counts once.
- R3: When a trigger is accepted, busy rises and sampleHold stays low (sample) for exactly ACQ_CYCLES cycles.
- R4: After acquisition, sampleHold goes high (hold) and startConv stays low for exactly SETTLE_CYCLES cycles.
- R5: startConv is then high for exactly START_CYCLES cycles. sampleHold stays high throughout.
- R6: After the start pulse, the block waits until the synchronized status input has been seen high and is then low. It then asserts captureStrobe for one cycle, and on the next cycle sampleHold and busy are both low.
- R7: A trigger that qualifies while busy is high is dropped and is not queued.
- R8: A trigger that qualifies fewer than MIN_PERIOD_CYCLES cycles after the previous accepted trigger is dropped.
- R9: If the wait for the status line lasts TIMEOUT_CYCLES cycles without completing, the block returns to idle with no capture strobe and sets timeoutErr. The next accepted trigger clears timeoutErr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| trigIn | input | 1 | Asynchronous trigger request |
| eocIn | input | 1 | Converter status, high while converting |
| sampleHold | output | 1 | Sample-hold control: 0 sample, 1 hold |
| startConv | output | 1 | Active-high start-convert pulse |
| captureStrobe | output | 1 | One-cycle strobe: converter data valid |
| busy | output | 1 | Sequence in progress |
| timeoutErr | output | 1 | Sticky conversion-timeout flag |

## Verification
The hardest case to reach from the ports is a trigger that qualifies right at the edge of the spacing window. Here a single cycle decides whether the trigger is accepted or dropped. The bench reaches it by sweeping the gap between two trigger pulses across that boundary, cycle by cycle. A behavioural model predicts each outcome and is compared with the outputs on every clock. A bench converter model can hold the status line stuck high, or never raise it at all. This drives the timeout path both with and without a seen rising edge.

// File: rtl/sh_seq_pkg.sv
package sh_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_ACQ    = 3'd1,
    PH_SETTLE = 3'd2,
    PH_START  = 3'd3,
    PH_CONV   = 3'd4,
    PH_CAPT   = 3'd5
  } phase_t;

  // control -> datapath
  typedef struct packed {
    logic accept;      // trigger taken this cycle
    logic cntClr;      // restart phase counter
    logic inConv;      // waiting for converter status
    logic timeoutSet;  // conversion gave up
  } ctrlStrobes_t;

  // datapath -> control
  typedef struct packed {
    logic trigQual;
    logic rateOk;
    logic acqDone;
    logic settleDone;
    logic startDone;
    logic convDone;
    logic convExpired;
  } dpStatus_t;

endpackage

// File: rtl/sh_seq_datapath.sv
module sh_seq_datapath
  import sh_seq_pkg::*;
#(
  parameter int ACQ_CYCLES      = 600,
  parameter int SETTLE_CYCLES   = 100,
  parameter int START_CYCLES    = 10,
  parameter int MIN_TRIG_CYCLES = 10,
  parameter int MIN_PERIOD_CYCLES = 1429,
  parameter int TIMEOUT_CYCLES  = 900
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         trigIn,
  input  logic         eocIn,
  input  ctrlStrobes_t strobes,
  output dpStatus_t    status,
  output logic         timeoutFlag
);

  localparam int MAX_A   = (ACQ_CYCLES > SETTLE_CYCLES) ? ACQ_CYCLES : SETTLE_CYCLES;
  localparam int MAX_B   = (START_CYCLES > TIMEOUT_CYCLES) ? START_CYCLES : TIMEOUT_CYCLES;
  localparam int MAX_PH  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_PH + 1);
  localparam int TW      = $clog2(MIN_TRIG_CYCLES + 1);
  localparam int PW      = $clog2(MIN_PERIOD_CYCLES + 1);
  localparam logic [TW-1:0]    TRIG_LAST = TW'(MIN_TRIG_CYCLES - 1);
  localparam logic [TW-1:0]    TRIG_SAT  = TW'(MIN_TRIG_CYCLES);
  localparam logic [PW-1:0]    PER_SAT   = PW'(MIN_PERIOD_CYCLES - 1);

  logic trigS1, trigS2, eocS1, eocS2;
  logic [TW-1:0]    widthCnt;
  logic [PW-1:0]    periodCnt;
  logic [CNT_W-1:0] phaseCnt;
  logic             eocSeen;

  // two-flop synchronizers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigS1 <= 1'b0;
      trigS2 <= 1'b0;
      eocS1  <= 1'b0;
      eocS2  <= 1'b0;
    end else begin
      trigS1 <= trigIn;
      trigS2 <= trigS1;
      eocS1  <= eocIn;
      eocS2  <= eocS1;
    end
  end

  // consecutive-high width counter, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      widthCnt <= '0;
    else if (!trigS2)
      widthCnt <= '0;
    else if (widthCnt != TRIG_SAT)
      widthCnt <= widthCnt + 1'b1;
  end

  // spacing counter since last accepted trigger
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      periodCnt <= PER_SAT;
    else if (strobes.accept)
      periodCnt <= '0;
    else if (periodCnt != PER_SAT)
      periodCnt <= periodCnt + 1'b1;
  end

  // phase duration counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      phaseCnt <= '0;
    else if (strobes.cntClr)
      phaseCnt <= '0;
    else
      phaseCnt <= phaseCnt + 1'b1;
  end

  // status-line tracking and error flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eocSeen     <= 1'b0;
      timeoutFlag <= 1'b0;
    end else begin
      if (strobes.accept)
        eocSeen <= 1'b0;
      else if (strobes.inConv && eocS2)
        eocSeen <= 1'b1;

      if (strobes.accept)
        timeoutFlag <= 1'b0;
      else if (strobes.timeoutSet)
        timeoutFlag <= 1'b1;
    end
  end

  always_comb begin
    status.trigQual    = trigS2 && (widthCnt == TRIG_LAST);
    status.rateOk      = (periodCnt == PER_SAT);
    status.acqDone     = (phaseCnt == CNT_W'(ACQ_CYCLES - 1));
    status.settleDone  = (phaseCnt == CNT_W'(SETTLE_CYCLES - 1));
    status.startDone   = (phaseCnt == CNT_W'(START_CYCLES - 1));
    status.convDone    = eocSeen && !eocS2;
    status.convExpired = (phaseCnt == CNT_W'(TIMEOUT_CYCLES - 1));
  end

endmodule

// File: rtl/sh_seq_control.sv
module sh_seq_control
  import sh_seq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  dpStatus_t    status,
  output ctrlStrobes_t strobes,
  output logic         sampleHold,
  output logic         startConv,
  output logic         captureStrobe,
  output logic         busy
);

  phase_t phase, phaseNext;
  logic   acceptNow;
  logic   giveUp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      phase <= PH_IDLE;
    else
      phase <= phaseNext;
  end

  always_comb begin
    phaseNext = phase;
    acceptNow = 1'b0;
    giveUp    = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        if (status.trigQual && status.rateOk) begin
          acceptNow = 1'b1;
          phaseNext = PH_ACQ;
        end
      end
      PH_ACQ:    if (status.acqDone)    phaseNext = PH_SETTLE;
      PH_SETTLE: if (status.settleDone) phaseNext = PH_START;
      PH_START:  if (status.startDone)  phaseNext = PH_CONV;
      PH_CONV: begin
        if (status.convDone) begin
          phaseNext = PH_CAPT;
        end else if (status.convExpired) begin
          giveUp    = 1'b1;
          phaseNext = PH_IDLE;
        end
      end
      PH_CAPT:   phaseNext = PH_IDLE;
      default:   phaseNext = PH_IDLE;
    endcase
  end

  always_comb begin
    strobes.accept     = acceptNow;
    strobes.cntClr     = (phaseNext != phase);
    strobes.inConv     = (phase == PH_CONV);
    strobes.timeoutSet = giveUp;
  end

  assign sampleHold    = (phase == PH_SETTLE) || (phase == PH_START) ||
                         (phase == PH_CONV)   || (phase == PH_CAPT);
  assign startConv     = (phase == PH_START);
  assign captureStrobe = (phase == PH_CAPT);
  assign busy          = (phase != PH_IDLE);

endmodule

// File: rtl/sh_conv_sequencer.sv
module sh_conv_sequencer
  import sh_seq_pkg::*;
#(
  parameter int ACQ_CYCLES        = 600,
  parameter int SETTLE_CYCLES     = 100,
  parameter int START_CYCLES      = 10,
  parameter int MIN_TRIG_CYCLES   = 10,
  parameter int MIN_PERIOD_CYCLES = 1429,
  parameter int TIMEOUT_CYCLES    = 900
) (
  input  logic clk,
  input  logic rstN,
  input  logic trigIn,
  input  logic eocIn,
  output logic sampleHold,
  output logic startConv,
  output logic captureStrobe,
  output logic busy,
  output logic timeoutErr
);

  ctrlStrobes_t strobes;
  dpStatus_t    status;

  sh_seq_datapath #(
    .ACQ_CYCLES       (ACQ_CYCLES),
    .SETTLE_CYCLES    (SETTLE_CYCLES),
    .START_CYCLES     (START_CYCLES),
    .MIN_TRIG_CYCLES  (MIN_TRIG_CYCLES),
    .MIN_PERIOD_CYCLES(MIN_PERIOD_CYCLES),
    .TIMEOUT_CYCLES   (TIMEOUT_CYCLES)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .trigIn     (trigIn),
    .eocIn      (eocIn),
    .strobes    (strobes),
    .status     (status),
    .timeoutFlag(timeoutErr)
  );

  sh_seq_control ctl_i (
    .clk          (clk),
    .rstN         (rstN),
    .status       (status),
    .strobes      (strobes),
    .sampleHold   (sampleHold),
    .startConv    (startConv),
    .captureStrobe(captureStrobe),
    .busy         (busy)
  );

endmodule

// File: rtl/sh_conv_sequencer_chk.sv
module sh_conv_sequencer_chk #(
  parameter int ACQ_CYCLES    = 600,
  parameter int SETTLE_CYCLES = 100,
  parameter int START_CYCLES  = 10
) (
  input logic clk,
  input logic rstN,
  input logic sampleHold,
  input logic startConv,
  input logic captureStrobe,
  input logic busy,
  input logic timeoutErr
);

  int unsigned acqRun, settleRun, startRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acqRun    <= 0;
      settleRun <= 0;
      startRun  <= 0;
    end else begin
      acqRun    <= (busy && !sampleHold)      ? acqRun + 1    : 0;
      settleRun <= (sampleHold && !startConv && !captureStrobe && busy) ? settleRun + 1 : 0;
      startRun  <= startConv                  ? startRun + 1  : 0;
    end
  end

  AST_HOLD_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    sampleHold |-> busy);  // R3

  AST_ACQ_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sampleHold) |-> acqRun == ACQ_CYCLES);  // R3

  AST_SETTLE_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(startConv) |-> settleRun == SETTLE_CYCLES);  // R4

  AST_START_IN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    startConv |-> sampleHold);  // R5

  AST_START_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(startConv) |-> startRun == START_CYCLES);  // R5

  AST_CAPTURE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    captureStrobe |=> !captureStrobe && !busy && !sampleHold);  // R6

  AST_TIMEOUT_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutErr) |-> !busy && !captureStrobe && !$past(captureStrobe));  // R9

endmodule

bind sh_conv_sequencer sh_conv_sequencer_chk #(
  .ACQ_CYCLES   (ACQ_CYCLES),
  .SETTLE_CYCLES(SETTLE_CYCLES),
  .START_CYCLES (START_CYCLES)
) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .sampleHold   (sampleHold),
  .startConv    (startConv),
  .captureStrobe(captureStrobe),
  .busy         (busy),
  .timeoutErr   (timeoutErr)
);

// File: tb/sh_conv_sequencer_tb_top.sv
module sh_conv_sequencer_tb_top;

  localparam int ACQ = 20, SETTLE = 5, STARTW = 3, MINTRIG = 4, MINPER = 80, TMO = 30;
  localparam int CONV_DELAY = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trigIn = 1'b0;
  logic eocIn = 1'b0;
  logic sampleHold, startConv, captureStrobe, busy, timeoutErr;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int capSeen = 0;
  int convMode = 0;  // 0 normal, 1 stuck high, 2 never rises
  int convLeft = 0;

  // reference model state
  int mT1 = 0, mT2 = 0, mRun = 0, mPh = 0, mLeft = 0, mSeen = 0;
  int mE1 = 0, mE2 = 0, mTo = 0, mLastAcc = -1000000, mCyc = 0;

  always #5 clk = ~clk;

  sh_conv_sequencer #(
    .ACQ_CYCLES(ACQ), .SETTLE_CYCLES(SETTLE), .START_CYCLES(STARTW),
    .MIN_TRIG_CYCLES(MINTRIG), .MIN_PERIOD_CYCLES(MINPER), .TIMEOUT_CYCLES(TMO)
  ) dut_i (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .eocIn(eocIn),
    .sampleHold(sampleHold), .startConv(startConv), .captureStrobe(captureStrobe),
    .busy(busy), .timeoutErr(timeoutErr)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // behavioural model: phases 0 idle,1 acq,2 settle,3 start,4 wait,5 capture
  always @(posedge clk) begin
    if (!rstN) begin
      mT1 = 0; mT2 = 0; mRun = 0; mPh = 0; mLeft = 0; mSeen = 0;
      mE1 = 0; mE2 = 0; mTo = 0; mLastAcc = -1000000; mCyc = 0;
    end else begin
      automatic bit qual = (mT2 == 1) && (mRun + 1 == MINTRIG);
      automatic bit done = (mSeen == 1) && (mE2 == 0);
      automatic int ph = mPh;
      mCyc++;
      case (ph)
        0: if (qual && (mCyc - mLastAcc >= MINPER)) begin
             mPh = 1; mLeft = ACQ; mLastAcc = mCyc; mSeen = 0; mTo = 0;
           end
        1: begin mLeft--; if (mLeft == 0) begin mPh = 2; mLeft = SETTLE; end end
        2: begin mLeft--; if (mLeft == 0) begin mPh = 3; mLeft = STARTW; end end
        3: begin mLeft--; if (mLeft == 0) begin mPh = 4; mLeft = TMO; end end
        4: begin
             if (done) mPh = 5;
             else begin
               mLeft--;
               if (mLeft == 0) begin mPh = 0; mTo = 1; end
             end
             if (mE2 == 1) mSeen = 1;
           end
        default: mPh = 0;
      endcase
      if (mT2 == 1) mRun = (mRun < MINTRIG) ? mRun + 1 : mRun; else mRun = 0;
      mT2 = mT1; mT1 = trigIn;
      mE2 = mE1; mE1 = eocIn;
    end
  end

  // converter model, cycle compare, watchdog
  always @(negedge clk) begin
    cyc++;
    if (captureStrobe) capSeen++;
    if (rstN) begin
      check("R3 busy", busy, mPh != 0);
      if (sampleHold != (mPh >= 2)) check("R4 sampleHold", sampleHold, mPh >= 2);
      if (startConv != (mPh == 3)) check("R5 startConv", startConv, mPh == 3);
      if (captureStrobe != (mPh == 5)) check("R6 captureStrobe", captureStrobe, mPh == 5);
      if (timeoutErr != mTo) check("R9 timeoutErr", timeoutErr, mTo);
    end
    case (convMode)
      0: begin
           if (startConv) begin eocIn <= 1'b1; convLeft = CONV_DELAY; end
           else if (convLeft > 0) begin convLeft--; if (convLeft == 0) eocIn <= 1'b0; end
         end
      1: if (startConv) eocIn <= 1'b1;
      default: eocIn <= 1'b0;
    endcase
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<=150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic pulse(input int width);
    @(negedge clk);
    trigIn = 1'b1;
    repeat (width) @(negedge clk);
    trigIn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int capBefore;
    idle(3);
    check("R1 sampleHold", sampleHold, 0);
    check("R1 startConv", startConv, 0);
    check("R1 busy", busy, 0);
    check("R1 timeoutErr", timeoutErr, 0);
    rstN = 1'b1;
    idle(1);
    check("R1 captureStrobe", captureStrobe, 0);
    check("R1 busy after release", busy, 0);

    // normal conversion
    pulse(6);
    idle(100);
    check("R6 one capture", capSeen, 1);

    // too-short trigger
    pulse(MINTRIG - 1);
    idle(100);
    check("R2 short pulse ignored", capSeen, 1);

    // exact minimum width
    pulse(MINTRIG);
    idle(100);
    check("R2 minimum width accepted", capSeen, 2);

    // retrigger while busy
    pulse(5);
    idle(10);
    check("R7 busy during sequence", busy, 1);
    pulse(5);
    idle(150);
    check("R7 busy retrigger dropped", capSeen, 3);

    // retrigger too soon after finishing
    pulse(5);
    while (busy !== 1'b0 || capSeen == 3) @(negedge clk);
    pulse(5);
    idle(20);
    check("R8 early retrigger dropped", busy, 0);
    idle(200);
    pulse(5);
    idle(100);
    check("R8 later trigger accepted", capSeen, 5);

    // spacing boundary sweep, model decides acceptance
    for (int gap = MINPER - 4; gap <= MINPER + 3; gap++) begin
      idle(200);
      pulse(5);
      idle(gap - 6);
      pulse(5);
      idle(150);
    end

    // timeout with status stuck high
    idle(200);
    convMode = 1;
    capBefore = capSeen;
    pulse(5);
    idle(90);
    check("R9 timeout flagged", timeoutErr, 1);
    check("R9 no capture on timeout", capSeen, capBefore);
    convMode = 0; eocIn = 1'b0;
    idle(100);
    pulse(5);
    idle(8);
    check("R9 cleared by accepted trigger", timeoutErr, 0);
    idle(100);

    // timeout with status never rising
    idle(100);
    convMode = 2;
    capBefore = capSeen;
    pulse(5);
    idle(90);
    check("R9 timeout without status edge", timeoutErr, 1);
    check("R9 no capture without status edge", capSeen, capBefore);
    convMode = 0;
    idle(100);

    // long pulse counts once
    capBefore = capSeen;
    pulse(300);
    idle(100);
    check("R2 long pulse single sequence", capSeen, capBefore + 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule